// File: doc/BRIEF.md
# Unordered Prerequisite-Before-Trigger Checker

This block watches a set of N prerequisite event strobes, for example notifications that configuration registers were written, and one trigger strobe, for example a start command. A trigger is legal only once every prerequisite has been observed, and the order in which the prerequisites arrive does not matter. The block raises a sticky violation flag and a one-cycle report that says which event broke the rule and why.

A static mode input selects between two licensing policies. In rearm mode, each accepted trigger consumes the collected prerequisites, so the whole set must be seen again before the next trigger, and a prerequisite may appear only once between triggers. In one-time mode, the first complete set licenses every later trigger, and repeated prerequisites are harmless.

Top module: `prereq_gate_mon`

## Requirements
- R1: A trigger that arrives alone after every prerequisite has been seen, in any order, is accepted: no violation pulse follows.
- R2: A trigger that arrives alone while at least one prerequisite has not been seen gives a violation one cycle later with viol_kind = 3 and viol_src = N. A rejected trigger leaves the collected set unchanged.
- R3: In rearm mode (rearm_mode = 1), an accepted trigger clears every seen bit, so a second trigger with no new prerequisites is reported as in R2.
- R4: In one-time mode (rearm_mode = 0), seen bits are never cleared except by reset. Once the set is complete, every later trigger is accepted, and repeated prerequisites cause no violation.
- R5: In rearm mode, a prerequisite that arrives alone while its seen bit is already set gives viol_kind = 2 and viol_src = its index (0 to N-1).
- R6: When more than one strobe (prerequisites and trigger together) is high in a cycle, the result is viol_kind = 1 with viol_src = the lowest active prerequisite index. No event of that cycle is recorded or consumed.
- R7: viol_flag rises together with the first violation pulse and stays high until clr_viol is sampled high in a cycle with no new violation. A violation in the same cycle as clr_viol keeps the flag set.
- R8: Synchronous reset clears all seen bits, viol_flag, viol_pulse, viol_kind and viol_src.
- R9: All results are registered. viol_pulse is high for exactly the one cycle that follows the offending strobe cycle, and viol_kind is 0 when there is no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rearm_mode | input | 1 | 1: each trigger consumes the set; 0: one complete set licenses all triggers (static) |
| clr_viol | input | 1 | Synchronous clear of the sticky violation flag |
| pre_evt | input | N | One strobe per prerequisite event |
| trig_evt | input | 1 | Trigger event strobe |
| viol_flag | output | 1 | Sticky violation flag |
| viol_pulse | output | 1 | One-cycle violation report |
| viol_kind | output | 2 | Cause: 0 none, 1 multiple strobes, 2 repeated prerequisite, 3 early trigger |
| viol_src | output | $clog2(N+1) | Offending event: prerequisite index, or N for the trigger |

## Verification
Every result is due exactly one clock edge after the strobe cycle that caused it. The bench drives each stimulus just after a rising edge and queues its expected pulse, cause, source and flag. A monitor pops that entry just after the next rising edge and compares it there, so each queued entry lines up with the single register stage. Where a violation is expected not to happen, the absence of a pulse is checked on that same edge. Where seen-bit state matters, it is brought out by issuing a later trigger or prerequisite and watching its report.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_MULTI  = 2'd1,
        CAUSE_REPEAT = 2'd2,
        CAUSE_EARLY  = 2'd3
    } cause_e;

    typedef struct packed {
        cause_e cause;
        logic   consume;
        logic   record;
    } verdict_t;

    localparam int MAX_PRE = 16;

endpackage

// File: rtl/pgm_classifier.sv
module pgm_classifier
    import pgm_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  pre_evt,
    input  logic          trig_evt,
    input  logic [N-1:0]  seen,
    input  logic          rearm_mode,
    output verdict_t      verdict,
    output logic [CW-1:0] src_code
);
    logic [N:0]    all_evt;
    logic          lone;
    logic          multi;
    logic          set_full;
    logic [CW-1:0] low_idx;

    assign all_evt  = {trig_evt, pre_evt};
    assign lone     = ($countones(all_evt) == 1);
    assign multi    = ($countones(all_evt) > 1);
    assign set_full = &seen;

    always_comb begin
        low_idx = CW'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (pre_evt[i]) low_idx = CW'(i);
        end
    end

    always_comb begin
        verdict.cause   = CAUSE_NONE;
        verdict.consume = 1'b0;
        verdict.record  = 1'b0;
        src_code        = low_idx;
        if (multi) begin
            verdict.cause = CAUSE_MULTI;
        end else if (lone && trig_evt) begin
            src_code = CW'(N);
            if (set_full) verdict.consume = rearm_mode;
            else          verdict.cause   = CAUSE_EARLY;
        end else if (lone) begin
            verdict.record = 1'b1;
            if (rearm_mode && |(pre_evt & seen)) verdict.cause = CAUSE_REPEAT;
        end
    end

endmodule

// File: rtl/pgm_seen_bank.sv
module pgm_seen_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] mark,
    input  logic         wipe,
    output logic [N-1:0] seen
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || wipe)  seen[g] <= 1'b0;
            else if (mark[g]) seen[g] <= 1'b1;
        end
    end

endmodule

// File: rtl/pgm_reporter.sv
module pgm_reporter
    import pgm_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_viol,
    input  cause_e        cause,
    input  logic [CW-1:0] src_code,
    output logic          viol_flag,
    output logic          viol_pulse,
    output logic [1:0]    viol_kind,
    output logic [CW-1:0] viol_src
);
    logic hit;
    assign hit = (cause != CAUSE_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_flag  <= 1'b0;
            viol_pulse <= 1'b0;
            viol_kind  <= 2'd0;
            viol_src   <= '0;
        end else begin
            viol_pulse <= hit;
            viol_kind  <= hit ? cause : CAUSE_NONE;
            if (hit) viol_src <= src_code;
            if (hit)           viol_flag <= 1'b1;
            else if (clr_viol) viol_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/prereq_gate_mon.sv
module prereq_gate_mon
    import pgm_pkg::*;
#(
    parameter int N  = 4,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rearm_mode,
    input  logic          clr_viol,
    input  logic [N-1:0]  pre_evt,
    input  logic          trig_evt,
    output logic          viol_flag,
    output logic          viol_pulse,
    output logic [1:0]    viol_kind,
    output logic [CW-1:0] viol_src
);
    verdict_t      verdict;
    logic [CW-1:0] src_code;
    logic [N-1:0]  seen_q;
    logic [N-1:0]  mark;

    if (N < 1 || N > MAX_PRE) begin : g_bad_n
        initial $error("prereq_gate_mon: N out of range");
    end

    assign mark = verdict.record ? pre_evt : '0;

    pgm_classifier #(.N(N), .CW(CW)) u_cls (
        .pre_evt    (pre_evt),
        .trig_evt   (trig_evt),
        .seen       (seen_q),
        .rearm_mode (rearm_mode),
        .verdict    (verdict),
        .src_code   (src_code)
    );

    pgm_seen_bank #(.N(N)) u_seen (
        .clk  (clk),
        .rst  (rst),
        .mark (mark),
        .wipe (verdict.consume),
        .seen (seen_q)
    );

    pgm_reporter #(.CW(CW)) u_rep (
        .clk        (clk),
        .rst        (rst),
        .clr_viol   (clr_viol),
        .cause      (verdict.cause),
        .src_code   (src_code),
        .viol_flag  (viol_flag),
        .viol_pulse (viol_pulse),
        .viol_kind  (viol_kind),
        .viol_src   (viol_src)
    );

endmodule

// File: rtl/prereq_gate_chk.sv
module prereq_gate_chk #(
    parameter int N  = 4,
    parameter int CW = $clog2(N + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          rearm_mode,
    input logic          clr_viol,
    input logic [N-1:0]  pre_evt,
    input logic          trig_evt,
    input logic [N-1:0]  seen_q,
    input logic          viol_flag,
    input logic          viol_pulse,
    input logic [1:0]    viol_kind,
    input logic [CW-1:0] viol_src
);
    // R6
    multi_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones({trig_evt, pre_evt}) > 1) |=> (viol_pulse && viol_kind == 2'd1));

    // R2
    early_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_evt && pre_evt == '0 && !(&seen_q)) |=> (viol_kind == 2'd3 && viol_src == CW'(N)));

    // R3
    rearm_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        (rearm_mode && trig_evt && pre_evt == '0 && (&seen_q)) |=> (seen_q == '0));

    // R4
    license_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!rearm_mode && (&seen_q)) |=> (&seen_q));

    // R7
    sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_flag && !clr_viol) |=> viol_flag);

    // R7
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |-> viol_flag);

    // R9
    quiet_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (!trig_evt && pre_evt == '0) |=> !viol_pulse);

endmodule

bind prereq_gate_mon prereq_gate_chk #(.N(N), .CW(CW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .rearm_mode (rearm_mode),
    .clr_viol   (clr_viol),
    .pre_evt    (pre_evt),
    .trig_evt   (trig_evt),
    .seen_q     (seen_q),
    .viol_flag  (viol_flag),
    .viol_pulse (viol_pulse),
    .viol_kind  (viol_kind),
    .viol_src   (viol_src)
);

// File: tb/prereq_gate_mon_tb_top.sv
module prereq_gate_mon_tb_top;
    localparam int N  = 4;
    localparam int CW = $clog2(N + 1);

    typedef struct {
        logic pulse;
        logic flag;
        int   kind;
        int   code;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rearm_mode = 1'b1;
    logic          clr_viol = 1'b0;
    logic [N-1:0]  pre_evt = '0;
    logic          trig_evt = 1'b0;
    logic          viol_flag;
    logic          viol_pulse;
    logic [1:0]    viol_kind;
    logic [CW-1:0] viol_src;

    int checks = 0;
    int errors = 0;
    exp_t sb_q[$];
    logic [N-1:0] m_seen = '0;
    logic         m_flag = 1'b0;

    always #10 clk = ~clk;

    prereq_gate_mon #(.N(N)) dut_i (
        .clk(clk), .rst(rst), .rearm_mode(rearm_mode), .clr_viol(clr_viol),
        .pre_evt(pre_evt), .trig_evt(trig_evt), .viol_flag(viol_flag),
        .viol_pulse(viol_pulse), .viol_kind(viol_kind), .viol_src(viol_src)
    );

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input logic [N-1:0] p, input logic t, input logic c, input string req);
        exp_t e;
        int   cnt;
        int   low;
        cnt = $countones({t, p});
        low = N;
        for (int i = N - 1; i >= 0; i--) if (p[i]) low = i;
        e.kind = 0;
        e.code = 0;
        if (cnt > 1) begin
            e.kind = 1; e.code = low;
        end else if (cnt == 1 && t) begin
            if (&m_seen) begin
                if (rearm_mode) m_seen = '0;
            end else begin
                e.kind = 3; e.code = N;
            end
        end else if (cnt == 1) begin
            if (rearm_mode && m_seen[low]) begin
                e.kind = 2; e.code = low;
            end
            m_seen[low] = 1'b1;
        end
        if (e.kind != 0) m_flag = 1'b1;
        else if (c)      m_flag = 1'b0;
        e.pulse = (e.kind != 0);
        e.flag  = m_flag;
        e.req   = req;
        @(posedge clk);
        #2;
        pre_evt  = p;
        trig_evt = t;
        clr_viol = c;
        sb_q.push_back(e);
    endtask

    // monitor: one register stage, so the result is checked one edge later
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp(e.req, "viol_pulse", int'(viol_pulse), int'(e.pulse));
            cmp(e.req, "viol_flag", int'(viol_flag), int'(e.flag));
            cmp(e.req, "viol_kind", int'(viol_kind), e.kind);
            if (e.pulse) cmp(e.req, "viol_src", int'(viol_src), e.code);
        end
    end

    task automatic do_reset(input logic mode);
        step('0, 1'b0, 1'b0, "R9");
        @(posedge clk);
        #2;
        rst = 1'b1;
        rearm_mode = mode;
        pre_evt = '0; trig_evt = 1'b0; clr_viol = 1'b0;
        m_seen = '0; m_flag = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        // R8 reset state
        cmp("R8", "viol_flag", int'(viol_flag), 0);
        cmp("R8", "viol_pulse", int'(viol_pulse), 0);
        cmp("R8", "viol_kind", int'(viol_kind), 0);
        cmp("R8", "viol_src", int'(viol_src), 0);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // rearm mode
        do_reset(1'b1);
        step('0, 1'b1, 1'b0, "R2");          // early trigger
        step('0, 1'b0, 1'b0, "R7");          // flag stays
        step('0, 1'b0, 1'b1, "R7");          // clear
        step(4'b0100, 1'b0, 1'b0, "R1");
        step(4'b0001, 1'b0, 1'b0, "R1");
        step(4'b1000, 1'b0, 1'b0, "R1");
        step(4'b0010, 1'b0, 1'b0, "R1");
        step('0, 1'b1, 1'b0, "R1");          // accepted
        step('0, 1'b1, 1'b0, "R3");          // consumed -> early
        step('0, 1'b0, 1'b1, "R7");
        step(4'b0010, 1'b0, 1'b0, "R5");
        step(4'b0010, 1'b0, 1'b0, "R5");     // duplicate
        step('0, 1'b0, 1'b1, "R7");
        step(4'b0101, 1'b0, 1'b0, "R6");     // collision, not recorded
        step(4'b0001, 1'b0, 1'b0, "R6");     // not a duplicate
        step(4'b1000, 1'b1, 1'b1, "R6");     // collision with clear: flag kept
        step('0, 1'b0, 1'b0, "R9");
        step('0, 1'b0, 1'b1, "R7");
        step(4'b0100, 1'b0, 1'b0, "R2");
        step('0, 1'b1, 1'b0, "R2");          // still incomplete (bit 3 missing)
        step(4'b1000, 1'b0, 1'b1, "R2");     // rejected trigger kept set
        step('0, 1'b1, 1'b0, "R2");          // now accepted
        // one-time mode
        do_reset(1'b0);
        step(4'b1000, 1'b0, 1'b0, "R4");
        step(4'b0010, 1'b0, 1'b0, "R4");
        step(4'b0001, 1'b0, 1'b0, "R4");
        step('0, 1'b1, 1'b0, "R2");
        step('0, 1'b0, 1'b1, "R7");
        step(4'b0001, 1'b0, 1'b0, "R4");     // repeat is harmless
        step(4'b0100, 1'b0, 1'b0, "R4");
        step('0, 1'b1, 1'b0, "R4");
        step('0, 1'b1, 1'b0, "R4");
        step(4'b0010, 1'b0, 1'b0, "R4");
        step('0, 1'b1, 1'b0, "R4");
        do_reset(1'b0);
        step('0, 1'b1, 1'b0, "R8");          // reset removed the license
        step('0, 1'b0, 1'b0, "R9");
        step('0, 1'b0, 1'b0, "R9");
        @(posedge clk);
        @(posedge clk);
        #5;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule